// File: doc/BRIEF.md
# Segmented Memory Address Generator

This block turns a register-relative or direct zero-page operand reference into a 20-bit byte address and a pair of byte-lane enables for a 16-bit processor. It holds four address registers, each a 16-bit base with its own 4-bit page. Register 0 acts as the program counter.

For a register-relative access the low sixteen address bits come from the chosen base. The top four bits are the page ORed with the 4-bit displacement carried in the instruction. A zero page in the page register gives object-style addressing, and a zero displacement gives linear addressing, with no mode bit.

A direct reference uses a 6-bit word index into a 64-word zero page. When the operand is headed for the program counter or the workspace pointer, a second 64-word vector page is used in its place. The result is registered and appears one clock after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mem_valid` is 0, `mem_lanes` is 00 and `mem_addr` is 0. All bases and pages reset to 0, so a word access to any register with displacement 0 then yields address 0.
- R2: A register-relative request (`acc_zp`=0) sampled at a rising edge gives `mem_valid`=1 after that edge. `mem_addr[15:1]` then equals bits 15..1 of the selected base.
- R3: For a register-relative request, `mem_addr[19:16]` is the bitwise OR of the selected register's page and `acc_disp`.
- R4: A page write (`page_we`) changes only the page of register `page_sel`. Its base and all other registers keep their values.
- R5: A base write (`base_we`) changes only the base of register `base_sel`. Its page and all other registers keep their values.
- R6: A word request (`acc_byte`=0) forces `mem_addr[0]` to 0 and drives `mem_lanes`=11.
- R7: A register-relative byte request (`acc_byte`=1) passes bit 0 of the base to `mem_addr[0]`. `mem_lanes` is 01 (low byte, bit 0 of the lanes) when that bit is 0, and 10 (high byte) when it is 1.
- R8: A zero-page request (`acc_zp`=1, `acc_dest_ctl`=0) gives an address whose bits 19..8 are 0, bit 7 is 0, bits 6..1 hold `acc_zp_idx` and bit 0 is 0. `mem_lanes` is 11. `acc_byte`, `acc_sel` and `acc_disp` have no effect.
- R9: A zero-page request with `acc_dest_ctl`=1 selects the vector page. Bit 7 of the address is 1 and all other bits are as in R8.
- R10: `acc_dest_ctl` has no effect on a register-relative request.
- R11: When a write and a request to the same register share an edge, the request uses the old contents. The new contents are used from the next request on.
- R12: A cycle with `acc_valid`=0 gives `mem_valid`=0 and `mem_lanes`=00 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Write the base of one register |
| base_sel | input | 2 | Register whose base is written |
| base_wdata | input | 16 | New base value |
| page_we | input | 1 | Write the page of one register |
| page_sel | input | 2 | Register whose page is written |
| page_wdata | input | 4 | New page value |
| acc_valid | input | 1 | Address request this cycle |
| acc_zp | input | 1 | 1: direct zero-page reference, 0: register-relative |
| acc_sel | input | 2 | Address register used for a register-relative request |
| acc_disp | input | 4 | Instruction displacement field |
| acc_zp_idx | input | 6 | Zero-page word index |
| acc_dest_ctl | input | 1 | Destination is program counter or workspace pointer |
| acc_byte | input | 1 | 1: byte access, 0: word access |
| mem_addr | output | 20 | Registered byte address |
| mem_lanes | output | 2 | Byte-lane enables, bit 0 low byte, bit 1 high byte |
| mem_valid | output | 1 | Address and lanes are for a request |

## Verification
The assertions assume that the select inputs always name one of the four registers. They also assume that the request fields are held steady only for the cycle in which `acc_valid` is high, and that `rst` is asserted for at least one edge before any request.

The bench drives every input on the falling edge and holds each request for exactly one cycle. It uses only select values from 0 to 3, so it stays inside those assumptions. It never relies on what `mem_addr` holds while `mem_valid` is 0.

// File: rtl/seg_agen_pkg.sv
`timescale 1ns/1ps
package seg_agen_pkg;
  typedef enum logic {
    KIND_REG = 1'b0,
    KIND_ZP  = 1'b1
  } acc_kind_e;

  typedef enum logic [1:0] {
    LANES_NONE = 2'b00,
    LANE_LO    = 2'b01,
    LANE_HI    = 2'b10,
    LANES_BOTH = 2'b11
  } lanes_e;
endpackage

// File: rtl/seg_agen_regs.sv
`timescale 1ns/1ps
module seg_agen_regs #(
  parameter int NUM_REGS = 4,
  parameter int BASE_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [SEL_W-1:0]  base_sel,
  input  logic [BASE_W-1:0] base_wdata,
  input  logic              page_we,
  input  logic [SEL_W-1:0]  page_sel,
  input  logic [PAGE_W-1:0] page_wdata,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [BASE_W-1:0] rd_base,
  output logic [PAGE_W-1:0] rd_page
);
  logic [BASE_W-1:0] base_q [NUM_REGS];
  logic [PAGE_W-1:0] page_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit_base;
    logic hit_page;
    assign hit_base = base_we && (base_sel == SEL_W'(i));
    assign hit_page = page_we && (page_sel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (rst)           base_q[i] <= '0;
      else if (hit_base) base_q[i] <= base_wdata;
    end

    always_ff @(posedge clk) begin
      if (rst)           page_q[i] <= '0;
      else if (hit_page) page_q[i] <= page_wdata;
    end

    // R4: a page write leaves the base of the same register alone
    p_page_keeps_base_r4: assert property (@(posedge clk) disable iff (rst)
      (hit_page && !hit_base) |=> $stable(base_q[i]));

    // R5: a base write leaves the page of the same register alone
    p_base_keeps_page_r5: assert property (@(posedge clk) disable iff (rst)
      (hit_base && !hit_page) |=> $stable(page_q[i]));
  end

  assign rd_base = base_q[rd_sel];
  assign rd_page = page_q[rd_sel];
endmodule

// File: rtl/seg_agen_form.sv
`timescale 1ns/1ps
module seg_agen_form
  import seg_agen_pkg::*;
#(
  parameter int BASE_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int ZP_IDX_W = 6,
  localparam int ADDR_W  = BASE_W + PAGE_W
) (
  input  acc_kind_e           kind,
  input  logic [BASE_W-1:0]   rd_base,
  input  logic [PAGE_W-1:0]   rd_page,
  input  logic [PAGE_W-1:0]   disp,
  input  logic [ZP_IDX_W-1:0] zp_idx,
  input  logic                dest_ctl,
  input  logic                byte_mode,
  output logic [ADDR_W-1:0]   addr_nxt,
  output lanes_e              lanes_nxt
);
  always_comb begin
    addr_nxt  = '0;
    lanes_nxt = LANES_BOTH;
    if (kind == KIND_ZP) begin
      addr_nxt[ZP_IDX_W:1]   = zp_idx;
      addr_nxt[ZP_IDX_W + 1] = dest_ctl;
    end else begin
      addr_nxt = {rd_page | disp, rd_base};
      if (byte_mode) lanes_nxt = rd_base[0] ? LANE_HI : LANE_LO;
      else           addr_nxt[0] = 1'b0;
    end
  end
endmodule

// File: rtl/seg_agen_oreg.sv
`timescale 1ns/1ps
module seg_agen_oreg
  import seg_agen_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_nxt,
  input  lanes_e            lanes_nxt,
  output logic [ADDR_W-1:0] addr_q,
  output logic [1:0]        lanes_q,
  output logic              valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      lanes_q <= LANES_NONE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) begin
        addr_q  <= addr_nxt;
        lanes_q <= lanes_nxt;
      end else begin
        lanes_q <= LANES_NONE;
      end
    end
  end

  // R12: no request, no lanes
  p_idle_no_lanes_r12: assert property (@(posedge clk) disable iff (rst)
    !load |=> (lanes_q == 2'b00) && !valid_q);

  // R6: both lanes only on an even address
  p_word_even_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_q && lanes_q == 2'b11) |-> (addr_q[0] == 1'b0));

  // R7: a single lane agrees with address bit 0
  p_byte_lane_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && $onehot0(lanes_q) && lanes_q != 2'b00) |-> (addr_q[0] == lanes_q[1]));

  // R2: a valid output always carries at least one lane
  p_valid_has_lane_r2: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ($countones(lanes_q) != 0));
endmodule

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
module seg_addr_gen
  import seg_agen_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int BASE_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int ZP_IDX_W = 6,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int ADDR_W  = BASE_W + PAGE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                base_we,
  input  logic [SEL_W-1:0]    base_sel,
  input  logic [BASE_W-1:0]   base_wdata,
  input  logic                page_we,
  input  logic [SEL_W-1:0]    page_sel,
  input  logic [PAGE_W-1:0]   page_wdata,
  input  logic                acc_valid,
  input  logic                acc_zp,
  input  logic [SEL_W-1:0]    acc_sel,
  input  logic [PAGE_W-1:0]   acc_disp,
  input  logic [ZP_IDX_W-1:0] acc_zp_idx,
  input  logic                acc_dest_ctl,
  input  logic                acc_byte,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [1:0]          mem_lanes,
  output logic                mem_valid
);
  logic [BASE_W-1:0] rd_base;
  logic [PAGE_W-1:0] rd_page;
  logic [ADDR_W-1:0] addr_nxt;
  lanes_e            lanes_nxt;
  acc_kind_e         kind;

  assign kind = acc_zp ? KIND_ZP : KIND_REG;

  seg_agen_regs #(
    .NUM_REGS(NUM_REGS), .BASE_W(BASE_W), .PAGE_W(PAGE_W), .SEL_W(SEL_W)
  ) regs_i (
    .clk(clk), .rst(rst),
    .base_we(base_we), .base_sel(base_sel), .base_wdata(base_wdata),
    .page_we(page_we), .page_sel(page_sel), .page_wdata(page_wdata),
    .rd_sel(acc_sel), .rd_base(rd_base), .rd_page(rd_page)
  );

  seg_agen_form #(
    .BASE_W(BASE_W), .PAGE_W(PAGE_W), .ZP_IDX_W(ZP_IDX_W)
  ) form_i (
    .kind(kind), .rd_base(rd_base), .rd_page(rd_page), .disp(acc_disp),
    .zp_idx(acc_zp_idx), .dest_ctl(acc_dest_ctl), .byte_mode(acc_byte),
    .addr_nxt(addr_nxt), .lanes_nxt(lanes_nxt)
  );

  seg_agen_oreg #(.ADDR_W(ADDR_W)) oreg_i (
    .clk(clk), .rst(rst), .load(acc_valid),
    .addr_nxt(addr_nxt), .lanes_nxt(lanes_nxt),
    .addr_q(mem_addr), .lanes_q(mem_lanes), .valid_q(mem_valid)
  );

  // R3: every displacement bit shows up in the upper address bits
  p_disp_in_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !$past(acc_zp)) |->
      ((mem_addr[ADDR_W-1:BASE_W] & $past(acc_disp)) == $past(acc_disp)));

  // R8: direct references stay inside the two low pages
  p_zp_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && $past(acc_zp)) |->
      (mem_addr[ADDR_W-1:ZP_IDX_W+2] == '0) && (mem_lanes == 2'b11));

  // R9: vector page bit follows the control destination flag
  p_vec_page_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && $past(acc_zp)) |-> (mem_addr[ZP_IDX_W+1] == $past(acc_dest_ctl)));
endmodule

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        base_we, page_we, acc_valid, acc_zp, acc_dest_ctl, acc_byte;
  logic [1:0]  base_sel, page_sel, acc_sel;
  logic [15:0] base_wdata;
  logic [3:0]  page_wdata, acc_disp;
  logic [5:0]  acc_zp_idx;
  logic [19:0] mem_addr;
  logic [1:0]  mem_lanes;
  logic        mem_valid;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [15:0] mb [4];
  logic [3:0]  mp [4];

  always #2 clk = ~clk;   // 250 MHz

  seg_addr_gen dut_i (
    .clk(clk), .rst(rst),
    .base_we(base_we), .base_sel(base_sel), .base_wdata(base_wdata),
    .page_we(page_we), .page_sel(page_sel), .page_wdata(page_wdata),
    .acc_valid(acc_valid), .acc_zp(acc_zp), .acc_sel(acc_sel),
    .acc_disp(acc_disp), .acc_zp_idx(acc_zp_idx), .acc_dest_ctl(acc_dest_ctl),
    .acc_byte(acc_byte),
    .mem_addr(mem_addr), .mem_lanes(mem_lanes), .mem_valid(mem_valid)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    base_we = 0; page_we = 0; acc_valid = 0; acc_zp = 0; acc_dest_ctl = 0;
    acc_byte = 0; base_sel = 0; page_sel = 0; acc_sel = 0;
    base_wdata = 0; page_wdata = 0; acc_disp = 0; acc_zp_idx = 0;
  endtask

  task automatic wr_base(int s, logic [15:0] v);
    @(negedge clk);
    base_we = 1; base_sel = 2'(s); base_wdata = v;
    @(negedge clk);
    base_we = 0;
    mb[s] = v;
  endtask

  task automatic wr_page(int s, logic [3:0] v);
    @(negedge clk);
    page_we = 1; page_sel = 2'(s); page_wdata = v;
    @(negedge clk);
    page_we = 0;
    mp[s] = v;
  endtask

  function automatic logic [19:0] exp_addr(bit zp, int s, logic [3:0] d,
                                           logic [5:0] ix, bit ctl, bit byt);
    logic [19:0] a;
    if (zp) begin
      a = 20'(ix) << 1;
      a[7] = ctl;
    end else begin
      a = {mp[s] | d, mb[s]};
      if (!byt) a[0] = 1'b0;
    end
    return a;
  endfunction

  function automatic logic [1:0] exp_lanes(bit zp, int s, bit byt);
    if (zp || !byt) return 2'b11;
    return mb[s][0] ? 2'b10 : 2'b01;
  endfunction

  // one request, held for one cycle; result sampled on the next falling edge
  task automatic req(string tag, bit zp, int s, logic [3:0] d,
                     logic [5:0] ix, bit ctl, bit byt);
    @(negedge clk);
    acc_valid = 1; acc_zp = zp; acc_sel = 2'(s); acc_disp = d;
    acc_zp_idx = ix; acc_dest_ctl = ctl; acc_byte = byt;
    @(negedge clk);
    acc_valid = 0;
    chk({tag, " valid"}, 32'(mem_valid), 32'd1);
    chk({tag, " addr"},  32'(mem_addr),  32'(exp_addr(zp, s, d, ix, ctl, byt)));
    chk({tag, " lanes"}, 32'(mem_lanes), 32'(exp_lanes(zp, s, byt)));
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", 32'(mem_valid), 0);
    chk("R1 lanes in reset", 32'(mem_lanes), 0);
    @(negedge clk); rst = 0;
    chk("R1 addr after reset", 32'(mem_addr), 0);
    chk("R1 valid after reset", 32'(mem_valid), 0);
    for (int i = 0; i < 4; i++) req("R1 zero regs", 0, i, 4'h0, 6'h0, 0, 0);
  endtask

  task automatic t_linear();
    wr_base(0, 16'h1234); wr_page(0, 4'h5);
    req("R2 linear", 0, 0, 4'h0, 6'h0, 0, 0);
    chk("R2 linear literal", 32'(mem_addr), 32'h51234);
  endtask

  task automatic t_object();
    wr_base(1, 16'hABCE);
    req("R3 object", 0, 1, 4'hA, 6'h0, 0, 0);
    chk("R3 object literal", 32'(mem_addr), 32'hAABCE);
    req("R3 page or disp", 0, 0, 4'h3, 6'h0, 0, 0);
    chk("R3 or literal", 32'(mem_addr), 32'h71234);
  endtask

  task automatic t_isolation();
    wr_base(2, 16'h4444);
    wr_page(2, 4'h9);
    req("R4 page write keeps base", 0, 2, 4'h0, 6'h0, 0, 0);
    chk("R4 literal", 32'(mem_addr), 32'h94444);
    wr_base(2, 16'h2222);
    req("R5 base write keeps page", 0, 2, 4'h0, 6'h0, 0, 0);
    chk("R5 literal", 32'(mem_addr), 32'h92222);
    req("R4 R5 neighbour untouched", 0, 1, 4'h0, 6'h0, 0, 0);
  endtask

  task automatic t_lanes();
    wr_base(3, 16'h0101);
    req("R6 word on odd base", 0, 3, 4'h0, 6'h0, 0, 0);
    chk("R6 bit0", 32'(mem_addr[0]), 0);
    req("R7 byte odd", 0, 3, 4'h0, 6'h0, 0, 1);
    chk("R7 high lane", 32'(mem_lanes), 32'h2);
    wr_base(3, 16'h0100);
    req("R7 byte even", 0, 3, 4'h0, 6'h0, 0, 1);
    chk("R7 low lane", 32'(mem_lanes), 32'h1);
  endtask

  task automatic t_zero_page();
    req("R8 zero page", 1, 0, 4'hF, 6'h2A, 0, 1);
    chk("R8 literal", 32'(mem_addr), 32'h54);
    req("R9 vector page", 1, 2, 4'h7, 6'h3F, 1, 0);
    chk("R9 literal", 32'(mem_addr), 32'hFE);
  endtask

  task automatic t_ctl_ignored();
    req("R10 ctl on reg access", 0, 0, 4'h2, 6'h15, 1, 0);
    chk("R10 literal", 32'(mem_addr), 32'h71234);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    base_we = 1; base_sel = 2'd1; base_wdata = 16'h0F00;
    acc_valid = 1; acc_zp = 0; acc_sel = 2'd1; acc_disp = 4'h0; acc_byte = 0;
    acc_dest_ctl = 0;
    @(negedge clk);
    base_we = 0; acc_valid = 0;
    chk("R11 old contents", 32'(mem_addr), 32'h0ABCE);
    mb[1] = 16'h0F00;
    req("R11 new contents", 0, 1, 4'h0, 6'h0, 0, 0);
  endtask

  task automatic t_idle();
    req("R12 before idle", 0, 0, 4'h0, 6'h0, 0, 0);
    @(negedge clk);
    chk("R12 valid low", 32'(mem_valid), 0);
    chk("R12 lanes off", 32'(mem_lanes), 0);
  endtask

  initial begin
    idle_inputs();
    for (int i = 0; i < 4; i++) begin mb[i] = '0; mp[i] = '0; end
    rst = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_linear();
    t_object();
    t_isolation();
    t_lanes();
    t_zero_page();
    t_ctl_ignored();
    t_same_cycle();
    t_idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule